// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps a 32-bit count of elapsed seconds for a system that needs wall-clock time without a calendar. A prescaler divides the system clock into a single-cycle tick once per second, and the counter advances by one on each tick. Software reads the live count over a simple APB-style slave port and can set it to any value. Writing a new count restarts the prescaler, so the first increment after a set comes one full second later.

A match value lets software schedule an alarm. When the count becomes equal to the match value, a sticky raw flag is set. The count wraps modulo 2^32, so a match value below the current count still fires once the counter rolls over. A one-bit enable gates the raw flag onto the interrupt output, and a write of any data to the clear register drops the flag. Fixed identification bytes sit in the last eight words of the 4 KB window.

The bus port has no wait states. Write data is taken on the clock edge that ends the access phase (`psel` and `penable` both high). Read data is a combinational function of the registered state and is valid throughout the access phase.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset the count, match value, last-set value, interrupt enable and raw flag all read 0, and `irq` is low.
- R2: With no set write, the count increases by exactly 1 once every `TICKS_PER_SEC` clock cycles and holds between ticks.
- R3: A write to word 0x08 replaces the count with the written data and restarts the prescaler, so the next increment is `TICKS_PER_SEC` cycles later. Reading 0x08 returns the last data written there, and reading 0x00 returns the live count.
- R4: When a set write and a prescaler tick fall in the same cycle, the written value is stored and the tick is discarded.
- R5: The raw flag sets when a tick moves the count onto the match value. This includes the roll-over from 0xFFFFFFFF to 0x00000000.
- R6: A write to the match word (0x04) or the set word (0x08) that makes the count equal to the match value sets the raw flag on the next cycle.
- R7: The enable register (0x10) keeps only data bit 0. Word 0x18 reads raw AND enable in bit 0, and `irq` equals that same value.
- R8: A write of any data to word 0x1C clears the raw flag. If an alarm event happens in the same cycle, the flag stays set.
- R9: Word 0x0C always reads 1. Writes to 0x00, 0x0C, 0x14 and 0x18 change no state.
- R10: Words 0xFE0, 0xFE4 … 0xFFC read, in bits 7:0 with upper bits 0, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that address order.
- R11: Reads of word 0x1C and of any unmapped word return 0.
- R12: Address bits 1:0 are ignored, so any byte address within a word selects that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address within the window |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access phase |
| irq | output | 1 | Alarm interrupt, high while raw flag and enable are both set |

## Verification
A wrong prescaler phase shows up at the ports within one second of a set write. The count read back drifts by one against a model that restarts timing at the set. A lost or spurious alarm event shows in the raw and masked words, and on `irq`, one cycle after the tick or write that should or should not have caused it. A mishandled same-cycle collision shows on the very next read: a tick against a set, or a clear against an event. The bench aligns writes to the tick on purpose to expose these collisions, and it compares every read against a cycle-by-cycle model built from the requirements.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  typedef struct packed {
    logic wrSet;
    logic wrMatch;
    logic wrEnable;
    logic wrClear;
  } rtcStrobes_t;

  // Word indices within the window (byte offset >> 2)
  localparam int W_COUNT  = 0;
  localparam int W_MATCH  = 1;
  localparam int W_SET    = 2;
  localparam int W_CTRL   = 3;
  localparam int W_ENABLE = 4;
  localparam int W_RAW    = 5;
  localparam int W_MASKED = 6;
  localparam int W_CLEAR  = 7;

  function automatic logic [7:0] idByte(input logic [2:0] k);
    case (k)
      3'd0: idByte = 8'h31;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-3:0]   wordIdx,
  input  logic [DATA_W-1:0]   countVal,
  input  logic [DATA_W-1:0]   matchVal,
  input  logic [DATA_W-1:0]   setVal,
  input  logic                enableBit,
  input  logic                rawSt,
  output rtcStrobes_t         strobes,
  output logic [DATA_W-1:0]   prdata
);

  localparam int WI_W = ADDR_W - 2;
  localparam logic [WI_W-1:0] ID_BASE = WI_W'((1 << WI_W) - 8);

  logic wrAcc;
  assign wrAcc = psel && penable && pwrite;

  always_comb begin
    strobes          = '0;
    strobes.wrSet    = wrAcc && (wordIdx == WI_W'(W_SET));
    strobes.wrMatch  = wrAcc && (wordIdx == WI_W'(W_MATCH));
    strobes.wrEnable = wrAcc && (wordIdx == WI_W'(W_ENABLE));
    strobes.wrClear  = wrAcc && (wordIdx == WI_W'(W_CLEAR));
  end

  always_comb begin
    prdata = '0;
    if (wordIdx >= ID_BASE) begin
      prdata[7:0] = idByte(wordIdx[2:0]);
    end else begin
      case (wordIdx)
        WI_W'(W_COUNT):  prdata = countVal;
        WI_W'(W_MATCH):  prdata = matchVal;
        WI_W'(W_SET):    prdata = setVal;
        WI_W'(W_CTRL):   prdata = DATA_W'(1);
        WI_W'(W_ENABLE): prdata = DATA_W'(enableBit);
        WI_W'(W_RAW):    prdata = DATA_W'(rawSt);
        WI_W'(W_MASKED): prdata = DATA_W'(rawSt & enableBit);
        default:         prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int TICKS_PER_SEC = 125_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       strobes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] matchVal,
  output logic [DATA_W-1:0] setVal,
  output logic              enableBit,
  output logic              rawSt,
  output logic              tickPulse
);

  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0]     presc;
  logic [DATA_W-1:0] nxtCount;
  logic [DATA_W-1:0] nxtMatch;
  logic              fireEv;

  assign tickPulse = (presc == LAST);

  // A set write outranks a tick arriving in the same cycle
  assign nxtCount = strobes.wrSet ? wdata
                  : tickPulse     ? countVal + DATA_W'(1)
                  :                 countVal;
  assign nxtMatch = strobes.wrMatch ? wdata : matchVal;
  assign fireEv   = (strobes.wrSet || strobes.wrMatch || tickPulse)
                    && (nxtCount == nxtMatch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc     <= '0;
      countVal  <= '0;
      matchVal  <= '0;
      setVal    <= '0;
      enableBit <= 1'b0;
      rawSt     <= 1'b0;
    end else begin
      presc    <= (strobes.wrSet || tickPulse) ? '0 : presc + PW'(1);
      countVal <= nxtCount;
      matchVal <= nxtMatch;
      if (strobes.wrSet)    setVal    <= wdata;
      if (strobes.wrEnable) enableBit <= wdata[0];
      if (fireEv)                rawSt <= 1'b1;
      else if (strobes.wrClear)  rawSt <= 1'b0;
    end
  end

endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
  import sec_rtc_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32,
  parameter int TICKS_PER_SEC = 125_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);

  rtcStrobes_t       strobes;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] matchVal;
  logic [DATA_W-1:0] setVal;
  logic              enableBit;
  logic              rawSt;
  logic              tickPulse;

  rtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .wordIdx(paddr[ADDR_W-1:2]),
    .countVal(countVal), .matchVal(matchVal), .setVal(setVal),
    .enableBit(enableBit), .rawSt(rawSt),
    .strobes(strobes), .prdata(prdata)
  );

  rtc_datapath #(.DATA_W(DATA_W), .TICKS_PER_SEC(TICKS_PER_SEC)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(pwdata),
    .countVal(countVal), .matchVal(matchVal), .setVal(setVal),
    .enableBit(enableBit), .rawSt(rawSt), .tickPulse(tickPulse)
  );

  assign irq = rawSt & enableBit;

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              irq,
  input logic [DATA_W-1:0] countVal,
  input logic              enableBit,
  input logic              rawSt,
  input logic              tickPulse
);

  localparam int WI_W = ADDR_W - 2;
  logic [WI_W-1:0] widx;
  logic wrAcc, rdAcc;
  assign widx  = paddr[ADDR_W-1:2];
  assign wrAcc = psel && penable && pwrite;
  assign rdAcc = psel && penable && !pwrite;

  p_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && widx == WI_W'(2)) |=> countVal == $past(pwdata));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrAcc && widx == WI_W'(2)) && !tickPulse) |=> $stable(countVal));

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrAcc && widx == WI_W'(2)) && tickPulse) |=> countVal == $past(countVal) + DATA_W'(1));

  p_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && widx == WI_W'(4)) |=> enableBit == $past(pwdata[0]));

  p_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rawSt && enableBit));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && widx == WI_W'(7) && !tickPulse) |=> !rawSt);

  p_fire_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && widx == WI_W'(1) && pwdata == countVal && !tickPulse) |=> rawSt);

  p_ctrl_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && widx == WI_W'(3)) |-> prdata == DATA_W'(1));

endmodule

bind sec_alarm_rtc rtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
  .countVal(countVal), .enableBit(enableBit), .rawSt(rawSt),
  .tickPulse(tickPulse)
);

// File: tb/sec_alarm_rtc_tb_top.sv
`timescale 1ns/1ps
module sec_alarm_rtc_tb_top;

  localparam int T = 8;

  logic        clk = 0;
  logic        rstN = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sec_alarm_rtc #(.ADDR_W(12), .DATA_W(32), .TICKS_PER_SEC(T)) dut_i (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  // Reference model built from the requirements
  logic [31:0] mCount, mMatch, mSet;
  logic        mEn, mRaw;
  int          mPresc;

  always @(posedge clk) begin
    logic wr, tk, wl, wm, we, wc, ev;
    logic [9:0] idx;
    logic [31:0] nc, nm;
    if (!rstN) begin
      mCount <= 0; mMatch <= 0; mSet <= 0; mEn <= 0; mRaw <= 0; mPresc <= 0;
    end else begin
      wr  = psel && penable && pwrite;
      idx = paddr[11:2];
      tk  = (mPresc == T-1);
      wl  = wr && idx == 2; wm = wr && idx == 1;
      we  = wr && idx == 4; wc = wr && idx == 7;
      nc  = wl ? pwdata : (tk ? mCount + 1 : mCount);
      nm  = wm ? pwdata : mMatch;
      ev  = (wl || tk || wm) && (nc == nm);
      mPresc <= (wl || tk) ? 0 : mPresc + 1;
      mCount <= nc;
      mMatch <= nm;
      if (wl) mSet <= pwdata;
      if (we) mEn <= pwdata[0];
      if (ev) mRaw <= 1;
      else if (wc) mRaw <= 0;
    end
  end

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic [7:0] ids [8];
    logic [9:0] idx;
    ids = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    idx = a[11:2];
    if (idx >= 10'h3F8) return {24'h0, ids[idx[2:0]]};
    case (idx)
      0: return mCount;
      1: return mMatch;
      2: return mSet;
      3: return 32'd1;
      4: return {31'h0, mEn};
      5: return {31'h0, mRaw};
      6: return {31'h0, mRaw & mEn};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge
  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic busRead(input logic [11:0] a, input string tag);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1;
    check(tag, prdata, expRead(a));
    check({tag, " irq"}, {31'h0, irq}, {31'h0, mRaw & mEn});
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt + 1);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [16];
    addrs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C,
              12'hFE0, 12'hFEC, 12'hFFC, 12'h020, 12'h400, 12'h00E, 12'h005, 12'hFF3};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 count", prdata, prdata);
    busRead(12'h000, "R1 count");
    busRead(12'h004, "R1 match");
    busRead(12'h008, "R1 set");
    busRead(12'h010, "R1 enable");
    busRead(12'h014, "R1 raw");
    check("R1 irq low", {31'h0, irq}, 32'h0);

    // R2 counting
    idle(3*T + 1);
    busRead(12'h000, "R2 count after ticks");

    // R3 set and readback
    busWrite(12'h008, 32'h0000_1000);
    busRead(12'h000, "R3 live count");
    busRead(12'h008, "R3 set readback");
    idle(T - 3);
    busRead(12'h000, "R3 full second after set");

    // R4 set collides with tick
    while (mPresc != T-2) @(negedge clk);
    busWrite(12'h008, 32'h0000_0500);
    check("R4 set wins over tick", mCount, 32'h0000_0500);
    busRead(12'h000, "R4 count");

    // R5 wrap alarm
    busWrite(12'h010, 32'hFFFF_FFFF);
    busRead(12'h010, "R7 enable keeps bit0");
    busWrite(12'h004, 32'h0000_0000);
    busWrite(12'h008, 32'hFFFF_FFFE);
    busWrite(12'h01C, 32'h0);
    busRead(12'h014, "R5 raw before wrap");
    idle(2*T + 2);
    busRead(12'h014, "R5 raw after wrap");
    check("R5 irq after wrap", {31'h0, irq}, 32'h1);
    busRead(12'h018, "R7 masked");

    // R8 clear with zero data
    busWrite(12'h01C, 32'h0);
    busRead(12'h014, "R8 raw cleared");
    check("R8 irq cleared", {31'h0, irq}, 32'h0);

    // R6 match write equal to count
    while (mPresc != 0) @(negedge clk);
    busWrite(12'h004, mCount);
    check("R6 raw immediate", {31'h0, mRaw}, 32'h1);
    busRead(12'h014, "R6 raw");
    busWrite(12'h01C, 32'hDEAD_BEEF);
    // R6 via set write
    busWrite(12'h008, mMatch);
    busRead(12'h014, "R6 raw via set");

    // R7 mask off
    busWrite(12'h010, 32'h0000_0002);
    busRead(12'h018, "R7 masked off");

    // R9 ignored writes
    busWrite(12'h00C, 32'h0);
    busRead(12'h00C, "R9 ctrl reads 1");
    busWrite(12'h000, 32'h1234_5678);
    busRead(12'h000, "R9 count unchanged");
    busWrite(12'h014, 32'h0);
    busWrite(12'h018, 32'h0);
    busRead(12'h014, "R9 raw unchanged");

    // R10 IDs
    for (int k = 0; k < 8; k++) busRead(12'hFE0 + 12'(4*k), "R10 id");

    // R11 zeros, R12 low bits
    busRead(12'h01C, "R11 clear reads 0");
    busRead(12'h800, "R11 unmapped");
    busRead(12'h00F, "R12 byte addr ctrl");
    busRead(12'h009, "R12 byte addr set");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: busWrite(12'h008, ($urandom_range(0,3) == 0) ? mMatch : $urandom);
        1: busWrite(12'h004, mCount + 32'($urandom_range(0, 3)));
        2: busWrite(12'h010, $urandom);
        3: busWrite(12'h01C, $urandom);
        4: busWrite({addrs[$urandom_range(0, 15)][11:2], 2'b00}, $urandom);
        5: idle($urandom_range(1, 2*T));
        default: busRead(addrs[$urandom_range(0, 15)], "R2 R5 R7 random read");
      endcase
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule